// File: doc/BRIEF.md
# SPI Master with Receive-Timeout Interrupt

This block is an SPI bus master that sits behind a small word-wide register port. Software writes a word to the data register. The word enters a transmit FIFO, and the shift engine sends it as one 16-bit frame in clock mode 3: the clock idles high, output data changes on falling edges and input data is sampled on rising edges, most significant bit first. The word shifted in during the same frame is pushed into a receive FIFO. Any read of the data register pops that FIFO, whoever issues the read.

A receive-timeout interrupt tells software that received data is waiting. The timeout counter runs in system clocks while the receive FIFO holds data and no timeout is pending. It raises the pending flag after a fixed number of bit-clock periods. Because of this condition, a handler that clears the flag before draining the FIFO sees the interrupt return one timeout later. A handler that drains first and then clears does not.

The raw flags are receive overrun, receive timeout and transmit level at half or below. Each is gated by a mask register, and the single interrupt output is the OR of the gated flags. The bit clock runs at the system clock divided by twice `half_period`.

Top module: `spi_rxto_master`

Register word addresses: 0 data, 1 status, 2 raw flags, 3 masked flags, 4 mask, 5 clear. All flags in the requirements below refer to these registers.

## Requirements
- R1: After reset, cs_n and sclk are 1, irq is 0, status reads 0x3, raw reads 0x8 and masked reads 0x0.
- R2: A data-register write produces one frame with exactly 16 falling sclk edges. mosi carries the written word MSB first, and sclk returns high between frames.
- R3: cs_n falls one half-period (half_period system clocks) before the first falling sclk edge. It rises one half-period after the last rising edge, and sclk is never low while cs_n is high.
- R4: Each completed frame pushes the word sampled from miso on rising edges into the receive FIFO. Data reads return those words oldest first. Status bit 2 (receive not empty) makes status read 0x7 after a frame with the transmit FIFO empty, and 0x3 once drained.
- R5: Raw bit 1 (timeout) sets 32 x 2 x half_period system clocks after the receive FIFO becomes non-empty, provided it stays non-empty and no timeout is pending.
- R6: Clearing bit 1 while data remains in the receive FIFO restarts the count, and bit 1 sets again one timeout later.
- R7: Draining the receive FIFO and then clearing bit 1 leaves bit 1 and irq low for longer than a timeout.
- R8: Masked reads raw AND mask (mask register bits 3:0), and irq is 1 exactly when masked is non-zero.
- R9: A frame completing into a full 8-entry receive FIFO drops its word and sets raw bit 0 (overrun). Writing 1 to clear-register bit 0 clears it.
- R10: A data read of an empty receive FIFO returns 0 and leaves the FIFO empty.
- R11: Raw bit 3 is 1 exactly when the transmit FIFO holds 4 or fewer words.
- R12: Clear-register bits written 0 change nothing. Bit 3 is a level and is not affected by the clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | 8 | System clocks per half bit period (0 is treated as 1) |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of bus_req |
| irq | output | 1 | Interrupt request, OR of masked flags |
| sclk | output | 1 | SPI bit clock, idles high |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The checker assumes three things about the block's inputs. half_period changes only while no frame is in flight. miso changes only on falling sclk edges. The register port issues one access per strobe. The bench's slave model drives miso only from falling clock edges. The bench picks a new divider only after a frame has ended and been read back. It samples the timeout flag a few clocks away from the exact threshold, so expected values do not hinge on a one-cycle race with the counter.

// File: rtl/spi_rxto_pkg.sv
`timescale 1ns/1ps
package spi_rxto_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSKD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;

  localparam int FLAG_W = 4;
  localparam int F_OVR  = 0;
  localparam int F_TO   = 1;
  localparam int F_TXH  = 3;

  localparam int S_TXE  = 0;
  localparam int S_TXNF = 1;
  localparam int S_RXNE = 2;
endpackage

// File: rtl/spi_rxto_fifo.sv
`timescale 1ns/1ps
module spi_rxto_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && (count != CW'(DEPTH));
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/spi_rxto_engine.sv
`timescale 1ns/1ps
module spi_rxto_engine #(
  parameter int FRAME_BITS = 16,
  parameter int HALF_W     = 8,
  localparam int PH_W      = $clog2(2*FRAME_BITS + 1) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HALF_W-1:0]     half,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  busy,
  output logic                  rx_valid,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2*FRAME_BITS);

  logic [HALF_W-1:0]     div_q;
  logic [PH_W-1:0]       ph_q;
  logic [FRAME_BITS-1:0] txsh_q, rxsh_q;
  logic                  tick;

  assign tick    = busy && ((half <= HALF_W'(1)) || (div_q == half - 1'b1));
  assign rx_word = rxsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rx_valid <= 1'b0;
      div_q    <= '0;
      ph_q     <= '0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
      sclk     <= 1'b1;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          txsh_q <= tx_word;
          ph_q   <= '0;
          div_q  <= '0;
        end
      end else if (tick) begin
        div_q <= '0;
        ph_q  <= ph_q + 1'b1;
        if (ph_q == PH_LAST) begin
          cs_n     <= 1'b1;
          busy     <= 1'b0;
          rx_valid <= 1'b1;
        end else if (!ph_q[0]) begin
          sclk   <= 1'b0;
          mosi   <= txsh_q[FRAME_BITS-1];
          txsh_q <= {txsh_q[FRAME_BITS-2:0], 1'b0};
        end else begin
          sclk   <= 1'b1;
          rxsh_q <= {rxsh_q[FRAME_BITS-2:0], miso};
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_rxto_timer.sv
`timescale 1ns/1ps
module spi_rxto_timer #(
  parameter int TO_BITS = 32,
  parameter int HALF_W  = 8,
  localparam int CNT_W  = $clog2(TO_BITS) + HALF_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half,
  input  logic              has_data,
  input  logic              clear,
  output logic              pending
);
  logic [CNT_W-1:0]  cnt_q, limit;
  logic [HALF_W-1:0] eff_half;

  assign eff_half = (half == '0) ? HALF_W'(1) : half;
  assign limit    = CNT_W'(TO_BITS) * CNT_W'({eff_half, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (has_data && !pending) begin
        if (cnt_q == limit - 1'b1) begin
          cnt_q   <= '0;
          pending <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
      if (clear) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rxto_master.sv
`timescale 1ns/1ps
module spi_rxto_master
  import spi_rxto_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int RX_DEPTH   = 8,
  parameter int TX_DEPTH   = 8,
  parameter int TO_BITS    = 32,
  parameter int HALF_W     = 8,
  localparam int RXC_W     = $clog2(RX_DEPTH) + 1,
  localparam int TXC_W     = $clog2(TX_DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [HALF_W-1:0]     half_period,
  input  logic                  bus_req,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [FRAME_BITS-1:0] bus_wdata,
  output logic [FRAME_BITS-1:0] bus_rdata,
  output logic                  irq,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso
);
  logic                  wr_hit, rd_hit;
  logic                  tx_push, tx_pop, rx_push, rx_pop;
  logic [FRAME_BITS-1:0] tx_dout, rx_dout, rx_word;
  logic [TXC_W-1:0]      tx_count;
  logic [RXC_W-1:0]      rx_count;
  logic                  busy, to_pend, ovr_q;
  logic [FLAG_W-1:0]     mask_q, clr_v, raw, masked;
  logic                  tx_empty, tx_nfull, rx_nempty, rx_full;

  assign wr_hit  = bus_req && bus_wr;
  assign rd_hit  = bus_req && !bus_wr;
  assign tx_push = wr_hit && (bus_addr == A_DATA);
  assign rx_pop  = rd_hit && (bus_addr == A_DATA);
  assign clr_v   = (wr_hit && (bus_addr == A_CLR)) ? bus_wdata[FLAG_W-1:0] : '0;

  assign tx_empty  = (tx_count == '0);
  assign tx_nfull  = (tx_count != TXC_W'(TX_DEPTH));
  assign rx_nempty = (rx_count != '0);
  assign rx_full   = (rx_count == RXC_W'(RX_DEPTH));
  assign tx_pop    = !busy && !tx_empty;

  spi_rxto_fifo #(.W(FRAME_BITS), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
    .din(bus_wdata), .dout(tx_dout), .count(tx_count));

  spi_rxto_fifo #(.W(FRAME_BITS), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
    .din(rx_word), .dout(rx_dout), .count(rx_count));

  spi_rxto_engine #(.FRAME_BITS(FRAME_BITS), .HALF_W(HALF_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .half(half_period), .start(tx_pop),
    .tx_word(tx_dout), .busy(busy), .rx_valid(rx_push), .rx_word(rx_word),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  spi_rxto_timer #(.TO_BITS(TO_BITS), .HALF_W(HALF_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .half(half_period), .has_data(rx_nempty),
    .clear(clr_v[F_TO]), .pending(to_pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_hit && (bus_addr == A_MASK)) mask_q <= bus_wdata[FLAG_W-1:0];
      if (rx_push && rx_full)  ovr_q <= 1'b1;
      else if (clr_v[F_OVR])   ovr_q <= 1'b0;
    end
  end

  always_comb begin
    raw        = '0;
    raw[F_OVR] = ovr_q;
    raw[F_TO]  = to_pend;
    raw[F_TXH] = (tx_count <= TXC_W'(TX_DEPTH/2));
  end
  assign masked = raw & mask_q;
  assign irq    = |masked;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_DATA:   bus_rdata = rx_nempty ? rx_dout : '0;
      A_STATUS: begin
        bus_rdata[S_TXE]  = tx_empty;
        bus_rdata[S_TXNF] = tx_nfull;
        bus_rdata[S_RXNE] = rx_nempty;
      end
      A_RAW:    bus_rdata[FLAG_W-1:0] = raw;
      A_MSKD:   bus_rdata[FLAG_W-1:0] = masked;
      A_MASK:   bus_rdata[FLAG_W-1:0] = mask_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_rxto_chk.sv
`timescale 1ns/1ps
module spi_rxto_chk #(
  parameter int RX_DEPTH = 8,
  localparam int RXC_W   = $clog2(RX_DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             cs_n,
  input logic             irq,
  input logic [3:0]       mask_q,
  input logic             to_pend,
  input logic             ovr_q,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [RXC_W-1:0] rx_count
);
  // R3
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !cs_n);

  // R8
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'd0) |-> !irq);

  // R5
  to_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_pend) |-> $past(rx_count != '0));

  // R9
  ovr_only_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_push && (rx_count == RXC_W'(RX_DEPTH))));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && (rx_count == '0) && !rx_push) |=> (rx_count == '0));

  // R4
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RXC_W'(RX_DEPTH));
endmodule

bind spi_rxto_master spi_rxto_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .irq(irq),
  .mask_q(mask_q), .to_pend(to_pend), .ovr_q(ovr_q), .rx_push(rx_push),
  .rx_pop(rx_pop), .rx_count(rx_count));

// File: tb/spi_rxto_master_tb.sv
`timescale 1ns/1ps
module spi_rxto_master_tb;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_period = 8'd2;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, sclk, cs_n, mosi;
  logic        miso = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  spi_rxto_master u_dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso));

  always #(CLK_NS/2) clk = ~clk;

  // slave and frame monitor
  int          frame_no = 0;
  int          bit_idx = 0;
  int          falls = 0, falls_last = 0;
  logic [15:0] mosi_sh = '0, mosi_last = '0;
  time         t_csf, t_ff, t_lr, t_csr;
  bit          first_fall = 0;

  function automatic logic [15:0] pat(input int n);
    return 16'h5A3C ^ (16'(n) * 16'h2F1B);
  endfunction

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge cs_n);
      t_csf = $time; bit_idx = 0; falls = 0; first_fall = 1;
    end
  end
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge sclk);
      if (first_fall) begin t_ff = $time; first_fall = 0; end
      falls++;
      miso = pat(frame_no)[15 - bit_idx];
      bit_idx++;
    end
  end
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge sclk);
      t_lr = $time;
      mosi_sh = {mosi_sh[14:0], mosi};
    end
  end
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge cs_n);
      t_csr = $time; mosi_last = mosi_sh; falls_last = falls; frame_no++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_req = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_req = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_frame(input int target);
    while (frame_no < target) @(negedge clk);
  endtask

  task automatic frame_shape(input string req2, input string req3,
                             input logic [15:0] word, input int h);
    chk({req2, " mosi word"}, 32'(mosi_last), 32'(word));
    chk({req2, " fall count"}, 32'(falls_last), 32'd16);
    chk({req3, " lead"}, 32'(t_ff - t_csf), 32'(h * CLK_NS));
    chk({req3, " trail"}, 32'(t_csr - t_lr), 32'(h * CLK_NS));
  endtask

  initial begin
    #4ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, raw_v, msk_v, word;
    int L, base, h;
    void'($urandom(32'd7321));
    #(3*CLK_NS) rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 1);
    chk("R1 sclk", 32'(sclk), 1);
    chk("R1 irq", 32'(irq), 0);
    rd(3'd1, d); chk("R1 status", 32'(d), 32'h3);
    rd(3'd2, d); chk("R1 raw", 32'(d), 32'h8);
    rd(3'd3, d); chk("R1 masked", 32'(d), 32'h0);

    // R2 R3 R4 R5 directed frame
    h = 2; half_period = 8'(h); L = 64 * h;
    wr(3'd4, 16'h2);
    base = frame_no;
    wr(3'd0, 16'hC3A5);
    wait_frame(base + 1);
    wait_cyc(L - 4);
    chk("R5 not yet", 32'(irq), 0);
    wait_cyc(8);
    chk("R5 fired", 32'(irq), 1);
    frame_shape("R2", "R3", 16'hC3A5, h);
    rd(3'd1, d); chk("R4 status full", 32'(d), 32'h7);
    rd(3'd2, d); chk("R5 raw", 32'(d), 32'hA);
    rd(3'd3, d); chk("R8 masked", 32'(d), 32'h2);
    rd(3'd0, d); chk("R4 data", 32'(d), 32'(pat(base)));
    rd(3'd1, d); chk("R4 status drained", 32'(d), 32'h3);
    wr(3'd5, 16'h2);
    chk("R7 cleared", 32'(irq), 0);
    wait_cyc(L + 10);
    chk("R7 quiet", 32'(irq), 0);

    // R6 clear before drain, then R7 drain then clear
    base = frame_no;
    wr(3'd0, 16'h0F0F);
    wait_frame(base + 1);
    wait_cyc(L + 4);
    chk("R6 first", 32'(irq), 1);
    wr(3'd5, 16'h2);
    chk("R6 cleared", 32'(irq), 0);
    wait_cyc(L - 6);
    chk("R6 before refire", 32'(irq), 0);
    wait_cyc(10);
    chk("R6 refire", 32'(irq), 1);
    rd(3'd0, d); chk("R4 data2", 32'(d), 32'(pat(base)));
    wr(3'd5, 16'h2);
    wait_cyc(L + 10);
    chk("R7 no refire", 32'(irq), 0);

    // R10 empty read
    rd(3'd0, d); chk("R10 empty data", 32'(d), 0);
    rd(3'd1, d); chk("R10 status", 32'(d), 32'h3);

    // R9 R11 R12 overrun
    h = 1; half_period = 8'(h); L = 64 * h;
    wr(3'd4, 16'h1);
    base = frame_no;
    for (int i = 0; i < 9; i++) wr(3'd0, 16'(i * 16'h1111));
    rd(3'd2, d); chk("R11 tx fill", 32'(d & 16'h8), 0);
    wait_frame(base + 9);
    wait_cyc(4);
    rd(3'd2, d); chk("R9 ovr set", 32'(d & 16'h9), 32'h9);
    chk("R8 irq ovr", 32'(irq), 1);
    wr(3'd5, 16'h0);
    rd(3'd2, d); chk("R12 zero write", 32'(d & 16'h1), 1);
    for (int i = 0; i < 8; i++) begin
      rd(3'd0, d); chk("R9 kept word", 32'(d), 32'(pat(base + i)));
    end
    rd(3'd0, d); chk("R9 dropped/R10", 32'(d), 0);
    wr(3'd5, 16'h1);
    rd(3'd2, d); chk("R9 ovr cleared", 32'(d & 16'h1), 0);
    wr(3'd5, 16'h8);
    rd(3'd2, d); chk("R12 level bit", 32'(d & 16'h8), 32'h8);
    wr(3'd5, 16'hF);

    // random frames: R2 R3 R5 R8 R11
    for (int it = 0; it < 16; it++) begin
      bit early;
      h = 1 + int'($urandom % 3); half_period = 8'(h); L = 64 * h;
      msk_v = 16'($urandom % 16);
      wr(3'd4, msk_v);
      word = 16'($urandom);
      early = 1'($urandom % 2);
      base = frame_no;
      wr(3'd0, word);
      wait_frame(base + 1);
      wait_cyc(early ? L - 8 : L + 6);
      rd(3'd2, raw_v);
      rd(3'd3, d);
      chk("R5 random raw", 32'(raw_v), early ? 32'h8 : 32'hA);
      chk("R8 random masked", 32'(d), 32'(raw_v & msk_v));
      chk("R8 random irq", 32'(irq), 32'(|(raw_v & msk_v)));
      frame_shape("R2 random", "R3 random", word, h);
      rd(3'd0, d); chk("R4 random data", 32'(d), 32'(pat(base)));
      wr(3'd5, 16'hF);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule